// File: doc/BRIEF.md
# Triple-Oversampled Serial Byte Receiver

This block receives asynchronous 8-N-1 bytes by treating the serial line like a synchronous port. A falling edge on the idle-high line starts a fixed capture of 29 samples, taken at three samples per bit. The data bits are then picked out of that captured word. Each decoded byte is pushed into a small receive FIFO. Software or a downstream block pops the FIFO through a first-word-fall-through read port.

The capture is one sample shorter than a full ten-bit frame: the stop bit is sampled only twice. As soon as the last sample is taken, the receiver goes back to watching for a start bit. A sender whose frames run up to one third of a bit short therefore never has its next start bit swallowed by the previous capture.

The sample rate comes from a divider value. One sample period lasts 2 × (div + 1) system clocks. The divider value is normally set to sysclk / (6 × baud) − 1.

Top module: `u3x_rx`

## Requirements
- R1: After a synchronous reset, `not_empty` is 0 and `ovf_flag` is 0.
- R2: One sample period lasts 2 × (`clk_div` + 1) system clocks, and one bit period is three sample periods. The line passes through a two-flop synchronizer before use. The first sample is taken half a sample period after the falling edge is seen. Bytes sent at this rate are received for more than one divider setting.
- R3: A frame is a low start bit, then 8 data bits sent least significant bit first, then a high stop bit. Each data bit is decided by the middle one of its three samples alone, so inverting the first and last third of a data bit does not change the byte.
- R4: The stop-bit samples are not checked. A frame whose first stop sample reads low is still written to the FIFO with its data intact.
- R5: Each capture is exactly 29 samples long. The receiver re-arms in the cycle after the 29th sample, so back-to-back frames whose stop bit lasts only two thirds of a bit are all received in order.
- R6: Received bytes are held in an 8-entry FIFO. They are read back in arrival order, and `not_empty` is 1 exactly while the FIFO holds data.
- R7: A byte that arrives while the FIFO is full, with no read in the same cycle, is dropped and sets `ovf_flag`. The 8 bytes already stored are kept.
- R8: `ovf_flag` stays set through reads and new traffic until `ovf_clear` is pulsed high. A set in the same cycle wins over a clear.
- R9: While `rx_enable` is 0, no frame is captured. Dropping `rx_enable` in the middle of a frame discards that frame. Reception works again once `rx_enable` returns to 1.
- R10: A read pulse while the FIFO is empty has no effect. `not_empty` stays 0 and later bytes are received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| clk_div | input | DIV_W (8) | Sample divider: sample period is 2 × (clk_div + 1) clocks |
| rx_enable | input | 1 | 1 lets the receiver capture frames |
| rd_en | input | 1 | Pop the FIFO head |
| rd_data | output | 8 | FIFO head byte (valid while not_empty) |
| not_empty | output | 1 | FIFO holds at least one byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clear | input | 1 | Write-one pulse that clears ovf_flag |

## Verification
The sharpest case is a stream of frames each one third of a bit short, sent back to back. A receiver that takes a full 30th sample would still be capturing when the next start edge arrives, so it would lose bytes or slip out of step. Data bits whose outer thirds are inverted catch a receiver that votes or samples off-centre, because it would decode wrong bits. A stop bit that reads low catches a receiver that wrongly discards framing-error bytes. The FIFO is overfilled by one byte to catch a design that overwrites stored data or fails to latch the flag, and the flag is checked again after a drain. Disabling mid-frame, and reading while empty, expose stray captures and a count that goes below zero.

// File: rtl/u3x_pkg.sv
package u3x_pkg;
    localparam int unsigned SAMPLES_PER_BIT = 3;
    localparam int unsigned DATA_BITS       = 8;
    localparam int unsigned CAPTURE_LEN     = 29;
    localparam int unsigned IDX_W           = $clog2(CAPTURE_LEN);

    typedef enum logic {CAP_IDLE = 1'b0, CAP_RUN = 1'b1} cap_state_t;

    typedef struct packed {
        logic                 valid;
        logic [DATA_BITS-1:0] data;
    } rx_byte_t;

    // Word is shifted in first sample at the top; bit k lives at 24 - 3k.
    function automatic logic [DATA_BITS-1:0] pick_bits(input logic [CAPTURE_LEN-1:0] w);
        logic [DATA_BITS-1:0] b;
        for (int k = 0; k < DATA_BITS; k++) begin
            b[k] = w[CAPTURE_LEN - 5 - SAMPLES_PER_BIT * k];
        end
        return b;
    endfunction
endpackage

// File: rtl/u3x_sync.sv
module u3x_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/u3x_tick.sv
module u3x_tick #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int unsigned CNT_W = DIV_W + 1;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (restart)      cnt <= {1'b0, div};
        else if (run) begin
            if (cnt == '0)     cnt <= {div, 1'b1};
            else               cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && !restart && (cnt == '0);

    // R2: ticks are at least two clocks apart
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/u3x_capture.sv
module u3x_capture
    import u3x_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     line,
    input  logic     tick,
    output logic     restart,
    output logic     running,
    output rx_byte_t out_byte
);
    cap_state_t             state;
    logic [IDX_W-1:0]       idx;
    logic [CAPTURE_LEN-2:0] shreg;
    logic                   last;

    assign running = (state == CAP_RUN);
    assign restart = enable && (state == CAP_IDLE) && !line;
    assign last    = running && tick && (idx == IDX_W'(CAPTURE_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state <= CAP_IDLE;
            idx   <= '0;
            shreg <= '0;
        end else if (restart) begin
            state <= CAP_RUN;
            idx   <= '0;
        end else if (running && tick) begin
            shreg <= {shreg[CAPTURE_LEN-3:0], line};
            idx   <= idx + 1'b1;
            if (last) state <= CAP_IDLE;
        end
    end

    always_comb begin
        out_byte.valid = last && enable;
        out_byte.data  = pick_bits({shreg, line});
    end

    // R9: nothing is produced in the cycle after enable is low
    a_r9_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !out_byte.valid);
    // R5: re-arm right after the last sample
    a_r5_rearm: assert property (@(posedge clk) disable iff (rst)
        out_byte.valid |=> (state == CAP_IDLE));
endmodule

// File: rtl/u3x_fifo.sv
module u3x_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             rd,
    output logic [WIDTH-1:0] rdata,
    output logic             not_empty,
    output logic             ovf,
    input  logic             ovf_clr
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    count;
    logic             full, do_rd, do_wr;

    assign full      = (count == CW'(DEPTH));
    assign not_empty = (count != '0);
    assign do_rd     = rd && not_empty;
    assign do_wr     = wr && (!full || do_rd);
    assign rdata     = mem[rp];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_wr) - CW'(do_rd);
            if (wr && !do_wr)  ovf <= 1'b1;
            else if (ovf_clr)  ovf <= 1'b0;
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r7_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (wr && full && !rd) |=> ovf);
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);
    a_r10_empty_read: assert property (@(posedge clk) disable iff (rst)
        (rd && !not_empty && !wr) |=> !not_empty);
endmodule

// File: rtl/u3x_rx.sv
module u3x_rx
    import u3x_pkg::*;
#(
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned FIFO_DEPTH  = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             rx_enable,
    input  logic             rd_en,
    output logic [7:0]       rd_data,
    output logic             not_empty,
    output logic             ovf_flag,
    input  logic             ovf_clear
);
    logic     line_s, tick, restart, running;
    rx_byte_t got;

    u3x_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(rx_line), .d_out(line_s)
    );

    u3x_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .restart(restart), .run(running),
        .div(clk_div), .tick(tick)
    );

    u3x_capture u_cap (
        .clk(clk), .rst(rst), .enable(rx_enable), .line(line_s),
        .tick(tick), .restart(restart), .running(running), .out_byte(got)
    );

    u3x_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_BITS)) u_fifo (
        .clk(clk), .rst(rst), .wr(got.valid), .wdata(got.data),
        .rd(rd_en), .rdata(rd_data), .not_empty(not_empty),
        .ovf(ovf_flag), .ovf_clr(ovf_clear)
    );

    // R1: reset leaves the FIFO empty and the flag clear
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (!not_empty && !ovf_flag));
endmodule

// File: tb/sim_u3x_rx.sv
module sim_u3x_rx;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_line = 1'b1;
    logic [7:0] clk_div = 8'd4;
    logic       rx_enable = 1'b0;
    logic       rd_en = 1'b0;
    logic       ovf_clear = 1'b0;
    logic [7:0] rd_data;
    logic       not_empty, ovf_flag;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    u3x_rx u0 (
        .clk(clk), .rst(rst), .rx_line(rx_line), .clk_div(clk_div),
        .rx_enable(rx_enable), .rd_en(rd_en), .rd_data(rd_data),
        .not_empty(not_empty), .ovf_flag(ovf_flag), .ovf_clear(ovf_clear)
    );

    // {stop length in thirds (3 nominal, 2 short), byte}
    localparam logic [9:0] VEC [8] = '{10'h3A5, 10'h200, 10'h3FF, 10'h25A,
                                       10'h301, 10'h280, 10'h37E, 10'h2C3};

    function automatic int period();
        return 2 * (int'(clk_div) + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl);
        rx_line = lvl;
        repeat (period()) @(negedge clk);
    endtask

    // glitch: invert the outer thirds of each data bit; stop_lo: first stop third low
    task automatic send(input logic [7:0] b, input int stop_thirds,
                        input bit glitch, input bit stop_lo);
        repeat (3) hold(1'b0);
        for (int k = 0; k < 8; k++) begin
            hold(glitch ? ~b[k] : b[k]);
            hold(b[k]);
            hold(glitch ? ~b[k] : b[k]);
        end
        for (int s = 0; s < stop_thirds; s++) hold((s == 0 && stop_lo) ? 1'b0 : 1'b1);
        rx_line = 1'b1;
    endtask

    task automatic settle();
        repeat (3 * period() + 4) @(negedge clk);
    endtask

    task automatic pop_expect(input logic [7:0] exp, input string req);
        check(not_empty === 1'b1, req, not_empty, 1);
        check(rd_data === exp, req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<200000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(not_empty === 1'b0, "R1", not_empty, 0);
        check(ovf_flag === 1'b0, "R1", ovf_flag, 0);
        rx_enable = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R5 R6: table walk, mixed nominal/short frames back to back
        for (int i = 0; i < 8; i++) send(VEC[i][7:0], int'(VEC[i][9:8]), 1'b0, 1'b0);
        settle();
        for (int i = 0; i < 8; i++) pop_expect(VEC[i][7:0], "R5 R6 table");
        check(not_empty === 1'b0, "R6", not_empty, 0);

        // R5: long stream of short frames, three batches of eight
        for (int bt = 0; bt < 3; bt++) begin
            for (int i = 0; i < 8; i++) send(8'(37 * (bt * 8 + i) + 11), 2, 1'b0, 1'b0);
            settle();
            for (int i = 0; i < 8; i++) pop_expect(8'(37 * (bt * 8 + i) + 11), "R5 short stream");
        end

        // R3: outer thirds inverted, middle decides
        send(8'h96, 3, 1'b1, 1'b0);
        send(8'h3C, 3, 1'b1, 1'b0);
        settle();
        pop_expect(8'h96, "R3");
        pop_expect(8'h3C, "R3");

        // R4: first stop sample low, byte still stored
        send(8'h5E, 3, 1'b0, 1'b1);
        settle();
        pop_expect(8'h5E, "R4");
        check(not_empty === 1'b0, "R4", not_empty, 0);

        // R2: another divider setting at nominal rate
        clk_div = 8'd1;
        send(8'hE7, 3, 1'b0, 1'b0);
        send(8'h18, 3, 1'b0, 1'b0);
        settle();
        pop_expect(8'hE7, "R2");
        pop_expect(8'h18, "R2");
        clk_div = 8'd4;

        // R10: read while empty
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check(not_empty === 1'b0, "R10", not_empty, 0);
        send(8'h42, 3, 1'b0, 1'b0);
        settle();
        pop_expect(8'h42, "R10");
        check(not_empty === 1'b0, "R10", not_empty, 0);

        // R7 R8: nine frames into eight slots
        for (int i = 0; i < 9; i++) send(8'(i + 8'h70), 3, 1'b0, 1'b0);
        settle();
        check(ovf_flag === 1'b1, "R7", ovf_flag, 1);
        for (int i = 0; i < 8; i++) pop_expect(8'(i + 8'h70), "R7");
        check(not_empty === 1'b0, "R7", not_empty, 0);
        check(ovf_flag === 1'b1, "R8", ovf_flag, 1);
        ovf_clear = 1'b1;
        @(negedge clk);
        ovf_clear = 1'b0;
        check(ovf_flag === 1'b0, "R8", ovf_flag, 0);

        // R9: disabled frame ignored
        rx_enable = 1'b0;
        send(8'h33, 3, 1'b0, 1'b0);
        settle();
        check(not_empty === 1'b0, "R9 disabled", not_empty, 0);
        rx_enable = 1'b1;
        repeat (3) @(negedge clk);
        // R9: mid-frame drop discards it
        fork
            send(8'hFF, 3, 1'b0, 1'b0);
            begin
                repeat (10 * period()) @(negedge clk);
                rx_enable = 1'b0;
                repeat (3) @(negedge clk);
                rx_enable = 1'b1;
            end
        join
        settle();
        check(not_empty === 1'b0, "R9 mid-frame", not_empty, 0);
        send(8'hC9, 3, 1'b0, 1'b0);
        settle();
        pop_expect(8'hC9, "R9 re-enabled");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule